// File: doc/BRIEF.md
# Audio Control Register Slave on a Two-Wire Serial Bus

This block lets a host microcontroller configure an audio decoder over a two-wire serial bus (I2C). The host addresses the slave, writes a one-byte register pointer, and then either streams data bytes into consecutive control registers or issues a repeated START and reads bytes back. The control registers select the audio switch routing, hold an adjustment value, and drive two open-collector port pins. A read-only status register exposes the stereo and dual-language identification flags. A fixed identification register at pointer 0xFE returns 0x80, so the host can tell which member of a device family is on the bus.

The bus lines are brought into the system clock domain through two-flop synchronizers. START and STOP are recovered from SDA edges while SCL is high. SDA is never driven high: the block only outputs a pull-down enable. A strap input selects which of two 7-bit addresses the slave answers to, so two devices can share one bus.

Top module: `audio_ctl_i2c`

## Requirements
- R1: With `addr_sel`=0 the slave acknowledges address 0x2C, and with `addr_sel`=1 it acknowledges address 0x2D. It does not acknowledge any other address, and it ignores the rest of that transfer until the next START.
- R2: In a write transfer the first byte after the address is the register pointer, and the slave acknowledges it.
- R3: Each data byte in a write is stored at the current pointer, and the pointer then increments. The pointer is 8 bits wide and wraps from 0xFF to 0x00.
- R4: Pointer 0 holds the switch selection (`sw_sel`) and pointer 1 holds the adjustment value (`adj_val`). Pointer 2 holds the port bits in bits [1:0] and reads back with zeros above them. Pointer 3 is status: bit 0 is the stereo flag and bit 1 is the dual flag, and bits 7:2 read as 0.
- R5: Pointer 0xFE reads 0x80. Writes to pointer 3, to 0xFE and to unmapped pointers are acknowledged but change nothing. Unmapped pointers read 0x00.
- R6: After a read address, the slave sends the register at the current pointer, MSB first. Each master ACK increments the pointer and sends the next register. The pointer survives STOP and repeated START.
- R7: After a master NACK the slave releases SDA and ignores the bus until the next START. Outside a transfer, `sda_pull` is low.
- R8: A START anywhere, even in the middle of a byte, restarts address reception. A STOP returns the slave to idle.
- R9: `sda_pull` changes only while the synchronized SCL is low.
- R10: Bit i of `port_pull` follows bit i of the register at pointer 2, and changes only through a write to that register.
- R11: Reset clears `sw_sel`, `adj_val`, `port_pull` and `sda_pull` to 0 and returns the slave to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_sel | input | 1 | Strap that selects the slave address |
| stereo_id | input | 1 | Stereo identification flag |
| dual_id | input | 1 | Dual-language identification flag |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it |
| port_pull | output | 2 | Open-collector port pull-down enables |
| sw_sel | output | 8 | Audio switch selection register |
| adj_val | output | 8 | Adjustment value register |

## Verification
The hardest state to reach is a START that arrives partway through a byte, which a well-behaved master never produces. The bench clocks out three stray bits and then issues a fresh START. It checks that the following write lands intact. Pointer wraparound, pointer retention across transfers, and the silent bus after a NACK are reached the same way: the bench chains transfers so that each one begins where the previous one left the pointer. It then probes SDA with extra clock pulses after the NACK.

// File: rtl/acb_pkg.sv
`timescale 1ns/1ps
package acb_pkg;
    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] saddr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } bus_state_t;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_SUB,
        PH_DATA
    } rx_phase_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_evt_t;

    localparam byte_t SUB_SWITCH = 8'h00;
    localparam byte_t SUB_ADJUST = 8'h01;
    localparam byte_t SUB_PORTS  = 8'h02;
    localparam byte_t SUB_STATUS = 8'h03;

    function automatic saddr_t pick_addr(input logic sel, input saddr_t a0, input saddr_t a1);
        return sel ? a1 : a0;
    endfunction
endpackage

// File: rtl/acb_line_sync.sv
`timescale 1ns/1ps
module acb_line_sync
    import acb_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt,
    output logic     scl_lvl
);
    localparam int M = STAGES - 1;

    logic [STAGES-1:0] scl_q, sda_q;
    logic              scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_d <= scl_q[M];
            sda_d <= sda_q[M];
        end
    end

    always_comb begin
        evt.start = scl_d & scl_q[M] & sda_d & ~sda_q[M];
        evt.stop  = scl_d & scl_q[M] & ~sda_d & sda_q[M];
        evt.rise  = ~scl_d & scl_q[M];
        evt.fall  = scl_d & ~scl_q[M];
        evt.sda   = sda_q[M];
        scl_lvl   = scl_q[M];
    end
endmodule

// File: rtl/acb_proto.sv
`timescale 1ns/1ps
module acb_proto
    import acb_pkg::*;
#(
    parameter saddr_t ADDR_A = 7'h2C,
    parameter saddr_t ADDR_B = 7'h2D
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_evt_t   evt,
    input  logic       addr_sel,
    input  byte_t      rd_data,
    output logic       sda_pull,
    output byte_t      sub,
    output logic       wr_en,
    output byte_t      wr_sub,
    output byte_t      wr_data,
    output bus_state_t state
);
    localparam logic [3:0] BITS = 4'(BYTE_W);

    rx_phase_t  phase;
    logic [3:0] cnt;
    byte_t      shreg;
    logic       rw;
    logic       mnack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            phase    <= PH_ADDR;
            cnt      <= '0;
            shreg    <= '0;
            rw       <= 1'b0;
            mnack    <= 1'b1;
            sub      <= '0;
            sda_pull <= 1'b0;
            wr_en    <= 1'b0;
            wr_sub   <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (evt.start) begin
                state    <= ST_RX;
                phase    <= PH_ADDR;
                cnt      <= '0;
                sda_pull <= 1'b0;
            end else if (evt.stop) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else begin
                unique case (state)
                    ST_RX: begin
                        if (evt.rise && cnt < BITS) begin
                            shreg <= {shreg[BYTE_W-2:0], evt.sda};
                            cnt   <= cnt + 4'd1;
                        end else if (evt.fall && cnt == BITS) begin
                            unique case (phase)
                                PH_ADDR: begin
                                    if (shreg[BYTE_W-1:1] == pick_addr(addr_sel, ADDR_A, ADDR_B)) begin
                                        rw       <= shreg[0];
                                        phase    <= PH_SUB;
                                        state    <= ST_ACK;
                                        sda_pull <= 1'b1;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                PH_SUB: begin
                                    sub      <= shreg;
                                    phase    <= PH_DATA;
                                    state    <= ST_ACK;
                                    sda_pull <= 1'b1;
                                end
                                default: begin
                                    wr_en    <= 1'b1;
                                    wr_sub   <= sub;
                                    wr_data  <= shreg;
                                    sub      <= sub + 8'd1;
                                    state    <= ST_ACK;
                                    sda_pull <= 1'b1;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (evt.fall) begin
                            cnt <= '0;
                            if (rw) begin
                                shreg    <= rd_data;
                                sda_pull <= ~rd_data[BYTE_W-1];
                                state    <= ST_TX;
                            end else begin
                                sda_pull <= 1'b0;
                                state    <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (evt.rise) begin
                            cnt <= cnt + 4'd1;
                        end else if (evt.fall) begin
                            if (cnt == BITS) begin
                                sda_pull <= 1'b0;
                                state    <= ST_MACK;
                            end else begin
                                shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_pull <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (evt.rise) begin
                            mnack <= evt.sda;
                            if (!evt.sda) sub <= sub + 8'd1;
                        end else if (evt.fall) begin
                            if (mnack) begin
                                state <= ST_IDLE;
                            end else begin
                                shreg    <= rd_data;
                                sda_pull <= ~rd_data[BYTE_W-1];
                                cnt      <= '0;
                                state    <= ST_TX;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/acb_regs.sv
`timescale 1ns/1ps
module acb_regs
    import acb_pkg::*;
#(
    parameter int    NPORT   = 2,
    parameter int    NSTAT   = 2,
    parameter byte_t ID_SUB  = 8'hFE,
    parameter byte_t ID_CODE = 8'h80
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  byte_t            wr_sub,
    input  byte_t            wr_data,
    input  byte_t            rd_sub,
    input  logic [NSTAT-1:0] stat_in,
    output byte_t            sw_sel,
    output byte_t            adj_val,
    output logic [NPORT-1:0] port_q,
    output byte_t            rd_data
);
    logic [NSTAT-1:0] stat_s;

    for (genvar g = 0; g < NSTAT; g++) begin : g_stat
        logic [1:0] ff;
        always_ff @(posedge clk) begin
            if (rst) ff <= '0;
            else     ff <= {ff[0], stat_in[g]};
        end
        assign stat_s[g] = ff[1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_sel  <= '0;
            adj_val <= '0;
            port_q  <= '0;
        end else if (wr_en) begin
            unique case (wr_sub)
                SUB_SWITCH: sw_sel  <= wr_data;
                SUB_ADJUST: adj_val <= wr_data;
                SUB_PORTS:  port_q  <= wr_data[NPORT-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (rd_sub)
            SUB_SWITCH: rd_data = sw_sel;
            SUB_ADJUST: rd_data = adj_val;
            SUB_PORTS:  rd_data = byte_t'(port_q);
            SUB_STATUS: rd_data = byte_t'(stat_s);
            ID_SUB:     rd_data = ID_CODE;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/audio_ctl_i2c.sv
`timescale 1ns/1ps
module audio_ctl_i2c
    import acb_pkg::*;
#(
    parameter saddr_t ADDR_A   = 7'h2C,
    parameter saddr_t ADDR_B   = 7'h2D,
    parameter int     NPORT    = 2,
    parameter int     SYNC_LEN = 2,
    parameter byte_t  ID_SUB   = 8'hFE,
    parameter byte_t  ID_CODE  = 8'h80
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             addr_sel,
    input  logic             stereo_id,
    input  logic             dual_id,
    output logic             sda_pull,
    output logic [NPORT-1:0] port_pull,
    output logic [7:0]       sw_sel,
    output logic [7:0]       adj_val
);
    bus_evt_t   evt;
    logic       scl_lvl;
    byte_t      sub, wr_sub, wr_data, rd_data;
    logic       wr_en;
    bus_state_t state;

    acb_line_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .evt(evt), .scl_lvl(scl_lvl)
    );

    acb_proto #(.ADDR_A(ADDR_A), .ADDR_B(ADDR_B)) u_proto (
        .clk(clk), .rst(rst), .evt(evt), .addr_sel(addr_sel),
        .rd_data(rd_data), .sda_pull(sda_pull), .sub(sub),
        .wr_en(wr_en), .wr_sub(wr_sub), .wr_data(wr_data), .state(state)
    );

    acb_regs #(.NPORT(NPORT), .NSTAT(2), .ID_SUB(ID_SUB), .ID_CODE(ID_CODE)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sub(wr_sub),
        .wr_data(wr_data), .rd_sub(sub), .stat_in({dual_id, stereo_id}),
        .sw_sel(sw_sel), .adj_val(adj_val), .port_q(port_pull),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/acb_check.sv
`timescale 1ns/1ps
module acb_check
    import acb_pkg::*;
#(
    parameter int NPORT = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             sda_pull,
    input logic [NPORT-1:0] port_pull,
    input logic [7:0]       sw_sel,
    input logic [7:0]       adj_val,
    input logic             scl_lvl,
    input logic             wr_en,
    input byte_t            wr_sub,
    input byte_t            sub,
    input bus_state_t       state
);
    assert_pull_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
        (sda_pull != $past(sda_pull)) |-> !$past(scl_lvl));

    assert_idle_release_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_pull);

    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (sub == wr_sub + 8'd1));

    assert_port_write_only_R10: assert property (@(posedge clk) disable iff (rst)
        (port_pull != $past(port_pull)) |-> ($past(wr_en) && $past(wr_sub) == SUB_PORTS));

    assert_reset_clear_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sw_sel == 8'd0 && adj_val == 8'd0 && port_pull == '0 && !sda_pull));
endmodule

bind audio_ctl_i2c acb_check #(.NPORT(NPORT)) u_chk (
    .clk(clk), .rst(rst), .sda_pull(sda_pull), .port_pull(port_pull),
    .sw_sel(sw_sel), .adj_val(adj_val), .scl_lvl(scl_lvl), .wr_en(wr_en),
    .wr_sub(wr_sub), .sub(sub), .state(state)
);

// File: tb/sim_audio_ctl_i2c.sv
`timescale 1ns/1ps
module sim_audio_ctl_i2c;
    localparam int Q = 5;
    localparam logic [6:0] A0 = 7'h2C;
    localparam logic [6:0] A1 = 7'h2D;

    logic clk = 1'b0, rst = 1'b1, scl_i = 1'b1, m_sda = 1'b1;
    logic addr_sel = 1'b0, stereo_id = 1'b0, dual_id = 1'b0;
    wire  sda_i;
    logic sda_pull;
    logic [1:0] port_pull;
    logic [7:0] sw_sel, adj_val;

    assign sda_i = m_sda & ~sda_pull;
    always #2.5 clk = ~clk;

    audio_ctl_i2c u0 (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .addr_sel(addr_sel),
        .stereo_id(stereo_id), .dual_id(dual_id), .sda_pull(sda_pull),
        .port_pull(port_pull), .sw_sel(sw_sel), .adj_val(adj_val)
    );

    int vectors = 0, miscompares = 0, cyc = 0;
    bit busy = 1'b1, done = 1'b0;
    logic [7:0] m_sw = 8'h00, m_adj = 8'h00;
    logic [1:0] m_port = 2'b00;
    int m_sub = 0;

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void mdl_wr(input int s, input logic [7:0] d);
        case (s)
            0: m_sw = d;
            1: m_adj = d;
            2: m_port = d[1:0];
            default: ;
        endcase
    endfunction

    function automatic int mdl_rd(input int s);
        case (s)
            0: return int'(m_sw);
            1: return int'(m_adj);
            2: return int'(m_port);
            3: return int'({dual_id, stereo_id});
            254: return 'h80;
            default: return 0;
        endcase
    endfunction

    // compared every idle clock against the model (R4, R7, R10)
    always @(negedge clk) begin
        if (!rst && !busy && !done) begin
            check("R4 sw_sel", int'(sw_sel), int'(m_sw));
            check("R4 adj_val", int'(adj_val), int'(m_adj));
            check("R10 port_pull", int'(port_pull), int'(m_port));
            check("R7 sda idle", int'(sda_pull), 0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        busy = 1'b1;
        m_sda = 1'b1; tick(Q);
        scl_i = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        scl_i = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; tick(Q);
        scl_i = 1'b1; tick(Q);
        m_sda = 1'b1; tick(2*Q);
        busy = 1'b0;
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; tick(Q);
        scl_i = 1'b1; tick(2*Q);
        scl_i = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; tick(Q);
        scl_i = 1'b1; tick(Q);
        b = sda_i; tick(Q);
        scl_i = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output int acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        acked = b ? 0 : 1;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(!mack);
    endtask

    task automatic xfer_write(input logic [6:0] a, input logic [7:0] s, input int n,
                              input logic [7:0] d0, input logic [7:0] d1, input int exp_ack);
        int ack;
        logic [7:0] d;
        bus_start;
        send_byte({a, 1'b0}, ack);
        check("R1 address ack", ack, exp_ack);
        send_byte(s, ack);
        check("R2 pointer ack", ack, exp_ack);
        if (exp_ack != 0) m_sub = int'(s);
        for (int i = 0; i < n; i++) begin
            d = (i == 0) ? d0 : d1;
            send_byte(d, ack);
            check("R3 data ack", ack, exp_ack);
            if (exp_ack != 0) begin
                mdl_wr(m_sub, d);
                m_sub = (m_sub + 1) % 256;
            end
        end
        bus_stop;
    endtask

    task automatic release_probe;
        logic b;
        for (int i = 0; i < 9; i++) begin
            get_bit(b);
            check("R7 released after NACK", int'(b), 1);
        end
    endtask

    task automatic read_n(input logic [6:0] a, input int n, input string req);
        int ack;
        logic [7:0] d;
        send_byte({a, 1'b1}, ack);
        check("R6 read address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(d, i < n - 1);
            check(req, int'(d), mdl_rd(m_sub));
            if (i < n - 1) m_sub = (m_sub + 1) % 256;
        end
        release_probe;
        bus_stop;
    endtask

    task automatic xfer_read(input logic [6:0] a, input logic [7:0] s, input int n, input string req);
        int ack;
        bus_start;
        send_byte({a, 1'b0}, ack);
        check("R1 address ack", ack, 1);
        send_byte(s, ack);
        check("R2 pointer ack", ack, 1);
        m_sub = int'(s);
        bus_start;
        read_n(a, n, req);
    endtask

    task automatic do_reset;
        busy = 1'b1;
        rst = 1'b1; tick(4);
        rst = 1'b0;
        m_sw = 8'h00; m_adj = 8'h00; m_port = 2'b00; m_sub = 0;
        tick(2);
        check("R11 reset sw_sel", int'(sw_sel), 0);
        check("R11 reset adj_val", int'(adj_val), 0);
        check("R11 reset port_pull", int'(port_pull), 0);
        check("R11 reset sda_pull", int'(sda_pull), 0);
        busy = 1'b0;
        tick(10);
    endtask

    initial begin
        tick(3);
        do_reset;

        // R1 R2 R3 R4: two bytes from pointer 0
        xfer_write(A0, 8'h00, 2, 8'hA5, 8'h3C, 1);
        check("R4 switch value", int'(sw_sel), 'hA5);
        check("R4 adjust value", int'(adj_val), 'h3C);

        // R10: port bits
        xfer_write(A0, 8'h02, 1, 8'hFF, 8'h00, 1);
        check("R10 ports set", int'(port_pull), 3);
        xfer_write(A0, 8'h02, 1, 8'h02, 8'h00, 1);
        check("R10 ports partial", int'(port_pull), 2);

        // R1: foreign address ignored
        xfer_write(A1, 8'h00, 1, 8'h11, 8'h00, 0);
        check("R1 foreign address no write", int'(sw_sel), 'hA5);

        // R6: auto-increment read of four registers
        stereo_id = 1'b1;
        tick(6);
        xfer_read(A0, 8'h00, 4, "R6 sequential read");

        // R4 R5: status is read-only
        stereo_id = 1'b0; dual_id = 1'b1;
        tick(6);
        xfer_write(A0, 8'h03, 1, 8'hFF, 8'h00, 1);
        xfer_read(A0, 8'h03, 1, "R4 status read");

        // R5: identification register and unmapped pointer
        xfer_write(A0, 8'hFE, 1, 8'h12, 8'h00, 1);
        xfer_read(A0, 8'hFE, 1, "R5 ident code");
        xfer_read(A0, 8'h40, 1, "R5 unmapped reads zero");

        // R3: pointer wraps from 0xFF to 0x00
        xfer_write(A0, 8'hFF, 2, 8'h77, 8'h66, 1);
        check("R3 wrap to pointer 0", int'(sw_sel), 'h66);

        // R8: START in the middle of a byte
        bus_start;
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        xfer_write(A0, 8'h01, 1, 8'h5E, 8'h00, 1);
        check("R8 restart write", int'(adj_val), 'h5E);

        // R1: alternate address
        addr_sel = 1'b1;
        tick(4);
        xfer_write(A1, 8'h01, 1, 8'h42, 8'h00, 1);
        xfer_write(A0, 8'h01, 1, 8'h99, 8'h00, 0);
        check("R1 alternate address write", int'(adj_val), 'h42);
        xfer_read(A1, 8'h00, 2, "R1 alternate address read");
        addr_sel = 1'b0;
        tick(4);

        // R6: pointer retained, current-pointer read
        xfer_read(A0, 8'h01, 2, "R6 read from 1");
        bus_start;
        read_n(A0, 1, "R6 current pointer read");

        // R11: reset after activity
        do_reset;
        xfer_read(A0, 8'h00, 3, "R11 registers cleared");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule